// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller with Remap

This block gathers 39 peripheral interrupt request lines, gives each one a fixed priority level from 1 to 7 and a fixed vector number, and picks the most urgent pending request every clock. It presents the winner to the processor core as a 3-bit level, an 8-bit vector number, and the byte address of that vector's entry in a relocatable vector table. It also drives a request flag that tells the core the winner should be taken.

The core's current interrupt mask is an input. The request flag is raised only when the winning level is above that mask, or when the winner is at level 7, which cannot be masked. The single level-7 source is caught on its rising edge and held until the core acknowledges that vector. Every other source is level-sensitive and is cleared only by the peripheral that raised it.

Software writes two simple ports. One sets the vector-table base. The other fills two promotion slots, each of which lifts a chosen source to the top of level 6. The reset input is asynchronous and active low. Its release is expected to be synchronous to `clk`.

Top module: `prio_intc`

## Requirements
- R1: After reset, `lvl_o`, `vec_o`, `vec_addr_o` and `req_o` are all zero. The table base is zero and both promotion slots are empty.
- R2: Source 0 has level 7. A source i in 1..38 has level 6 - floor((i-1)/7), so sources 1-7 are at level 6 and sources 36-38 are at level 1.
- R3: The pending source with the highest level wins. Among sources at the same level, the lower source index wins.
- R4: The winner's vector number is 64 + source index. `vec_addr_o` = base + 4 × vector. With nothing pending, level, vector and address all read 0.
- R5: `req_o` is 1 only when a source is pending and its level is greater than `mask_i`, or equal to 7.
- R6: A level-sensitive source stops being reported one clock after its input falls. It is never latched.
- R7: A rising edge on source 0 is latched and stays reported after the input falls. The latch is cleared only by an acknowledge cycle (`ack_i`=1) that carries vector 64; any other acknowledged vector leaves it set. A held-high input does not re-latch after the clear.
- R8: A promotion-slot write selects slot 0 or 1 with `remap_sel_i`. Bit 6 of the written data is the valid flag and bits 5:0 are the source index. A promoted source is reported at level 6 and beats every other level-6 source. Slot 0 beats slot 1. Level 7 still beats both.
- R9: A slot whose valid flag is 0, or whose index is 39 or more, has no effect on selection.
- R10: A base write keeps bits 31:20 of the data and forces bits 19:0 to zero.
- R11: The outputs are registered. A change on `irq_i`, `mask_i` or the edge latch shows at the outputs on the first rising clock edge after it. A base or slot write shows at the outputs one edge after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 39 | Peripheral request lines, bit i is source i |
| mask_i | input | 3 | Core's current interrupt mask level |
| ack_i | input | 1 | Core acknowledge strobe |
| ack_vec_i | input | 8 | Vector number being acknowledged |
| base_we_i | input | 1 | Vector-table base write strobe |
| base_wdata_i | input | 32 | Vector-table base write data |
| remap_we_i | input | 1 | Promotion-slot write strobe |
| remap_sel_i | input | 1 | Promotion slot selected for the write |
| remap_wdata_i | input | 7 | Slot data: bit 6 valid, bits 5:0 source index |
| req_o | output | 1 | Interrupt request to the core |
| lvl_o | output | 3 | Winning level, 0 when idle |
| vec_o | output | 8 | Winning vector number, 0 when idle |
| vec_addr_o | output | 32 | Vector-table entry address, 0 when idle |

## Verification
A corrupted rank calculation or slot register shows up as a wrong vector number on the first clock after the stimulus that exposes it. The bench therefore samples the outputs exactly one or two edges after each stimulus, rather than waiting for them to settle. A stuck or early-cleared edge latch for source 0 shows as a level-7 report that outlives an acknowledge, or that disappears on a falling input or on the wrong acknowledged vector; each of these is checked two edges after the event. A bad base register shows in the upper address bits of the next reported vector.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LVL_W      = 3;
  localparam int VEC_W      = 8;
  localparam int IDX_W      = 6;
  localparam int ADDR_W     = 32;
  localparam int VEC_OFS    = 64;
  localparam int BASE_ALIGN = 20;
  localparam int RANK_W     = LVL_W + 2;
  localparam int GRP_SIZE   = 7;

  typedef struct packed {
    logic             vld;
    logic [IDX_W-1:0] idx;
  } slot_t;

  // Fixed level of a source: source 0 is the single non-maskable line,
  // then groups of GRP_SIZE sources step down from level 6 to a floor of 1.
  function automatic logic [LVL_W-1:0] src_level(input int i);
    int l;
    if (i == 0) return LVL_W'(7);
    l = 6 - (i - 1) / GRP_SIZE;
    if (l < 1) l = 1;
    return LVL_W'(l);
  endfunction
endpackage

// File: rtl/intc_cfg.sv
module intc_cfg
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 39
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        base_we_i,
  input  logic [ADDR_W-1:0]           base_wdata_i,
  input  logic                        remap_we_i,
  input  logic                        remap_sel_i,
  input  logic [IDX_W:0]              remap_wdata_i,
  output logic [ADDR_W-1:0]           base_o,
  output logic [1:0]                  slot_en_o,
  output logic [1:0][IDX_W-1:0]       slot_idx_o
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << BASE_ALIGN) - ADDR_W'(1));

  logic [ADDR_W-1:0] base_q, base_d;
  slot_t             slot_q [2];
  slot_t             slot_d [2];

  always_comb begin
    base_d = base_q;
    if (base_we_i) base_d = base_wdata_i & ALIGN_MASK;
  end

  for (genvar k = 0; k < 2; k++) begin : g_slot
    always_comb begin
      slot_d[k] = slot_q[k];
      if (remap_we_i && (remap_sel_i == k[0])) slot_d[k] = remap_wdata_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[k] <= '0;
      else        slot_q[k] <= slot_d[k];
    end
    // a slot counts only when flagged valid and naming an existing source
    assign slot_en_o[k]  = slot_q[k].vld && ({1'b0, slot_q[k].idx} < (IDX_W+1)'(NUM_SRC));
    assign slot_idx_o[k] = slot_q[k].idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  assign base_o = base_q;

  p_slot_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (remap_we_i && !remap_sel_i) |=> (slot_q[0] == $past(remap_wdata_i)));

  p_base_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    base_we_i |=> (base_q[ADDR_W-1:BASE_ALIGN] == $past(base_wdata_i[ADDR_W-1:BASE_ALIGN])));
endmodule

// File: rtl/intc_edge.sv
module intc_edge
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 39
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               ack_i,
  input  logic [VEC_W-1:0]   ack_vec_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (src_level(i) == LVL_W'(7)) begin : g_edge
      logic prev_q, pend_q, pend_d, rise, hit;
      assign rise = irq_i[i] & ~prev_q;
      assign hit  = ack_i && (ack_vec_i == VEC_W'(VEC_OFS + i));
      always_comb begin
        pend_d = pend_q;
        if (hit)  pend_d = 1'b0;
        if (rise) pend_d = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          prev_q <= irq_i[i];
          pend_q <= pend_d;
        end
      end
      assign pend_o[i] = pend_q | rise;

      p_edge_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !hit) |=> pend_q);
      p_edge_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !rise) |=> !pend_q);
    end else begin : g_level
      assign pend_o[i] = irq_i[i];
    end
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 39
) (
  input  logic [NUM_SRC-1:0]     pend_i,
  input  logic [1:0]             slot_en_i,
  input  logic [1:0][IDX_W-1:0]  slot_idx_i,
  output logic                   win_vld_o,
  output logic [LVL_W-1:0]       win_lvl_o,
  output logic [IDX_W-1:0]       win_idx_o
);
  logic [RANK_W-1:0] best_rank, cand;
  logic [IDX_W-1:0]  best_idx;
  logic              best_vld;

  // rank = {level, promotion}; scanning downward with >= lets the lower index win ties
  always_comb begin
    best_rank = '0;
    best_idx  = '0;
    best_vld  = 1'b0;
    cand      = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      cand = {src_level(i), 2'b00};
      if (slot_en_i[1] && (slot_idx_i[1] == IDX_W'(i))) cand = {LVL_W'(6), 2'b10};
      if (slot_en_i[0] && (slot_idx_i[0] == IDX_W'(i))) cand = {LVL_W'(6), 2'b11};
      if (pend_i[i] && (cand >= best_rank)) begin
        best_rank = cand;
        best_idx  = IDX_W'(i);
        best_vld  = 1'b1;
      end
    end
  end

  assign win_vld_o = best_vld;
  assign win_lvl_o = best_rank[RANK_W-1:2];
  assign win_idx_o = best_idx;
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 39
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic [2:0]         mask_i,
  input  logic               ack_i,
  input  logic [7:0]         ack_vec_i,
  input  logic               base_we_i,
  input  logic [31:0]        base_wdata_i,
  input  logic               remap_we_i,
  input  logic               remap_sel_i,
  input  logic [6:0]         remap_wdata_i,
  output logic               req_o,
  output logic [2:0]         lvl_o,
  output logic [7:0]         vec_o,
  output logic [31:0]        vec_addr_o
);
  logic [ADDR_W-1:0]          base;
  logic [1:0]                 slot_en;
  logic [1:0][IDX_W-1:0]      slot_idx;
  logic [NUM_SRC-1:0]         pend;
  logic                       win_vld;
  logic [LVL_W-1:0]           win_lvl;
  logic [IDX_W-1:0]           win_idx;

  logic                       req_d, req_q;
  logic [LVL_W-1:0]           lvl_d, lvl_q;
  logic [VEC_W-1:0]           vec_d, vec_q;
  logic [ADDR_W-1:0]          addr_d, addr_q;

  intc_cfg #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .base_we_i(base_we_i), .base_wdata_i(base_wdata_i),
    .remap_we_i(remap_we_i), .remap_sel_i(remap_sel_i), .remap_wdata_i(remap_wdata_i),
    .base_o(base), .slot_en_o(slot_en), .slot_idx_o(slot_idx)
  );

  intc_edge #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
    .ack_i(ack_i), .ack_vec_i(ack_vec_i), .pend_o(pend)
  );

  intc_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend_i(pend), .slot_en_i(slot_en), .slot_idx_i(slot_idx),
    .win_vld_o(win_vld), .win_lvl_o(win_lvl), .win_idx_o(win_idx)
  );

  always_comb begin
    lvl_d  = '0;
    vec_d  = '0;
    addr_d = '0;
    req_d  = 1'b0;
    if (win_vld) begin
      lvl_d  = win_lvl;
      vec_d  = VEC_W'(VEC_OFS) + VEC_W'(win_idx);
      addr_d = base + ADDR_W'({vec_d, 2'b00});
      req_d  = (win_lvl > mask_i) || (win_lvl == LVL_W'(7));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      lvl_q  <= '0;
      vec_q  <= '0;
      addr_q <= '0;
    end else begin
      req_q  <= req_d;
      lvl_q  <= lvl_d;
      vec_q  <= vec_d;
      addr_q <= addr_d;
    end
  end

  assign req_o      = req_q;
  assign lvl_o      = lvl_q;
  assign vec_o      = vec_q;
  assign vec_addr_o = addr_q;

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_o == 3'd0) |-> (vec_o == 8'd0 && vec_addr_o == 32'd0 && !req_o));
  p_vec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_o != 3'd0) |-> (vec_o >= 8'(VEC_OFS) && vec_o < 8'(VEC_OFS + NUM_SRC)));
  p_nmi_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_o == 3'd7) |-> req_o);
  p_req_lvl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (lvl_o != 3'd0));
  p_addr_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_o != 3'd0) |-> (vec_addr_o[BASE_ALIGN-1:0] == {12'd0, vec_o, 2'b00}));
endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [38:0] irq;
  logic [2:0]  mask;
  logic        ack;
  logic [7:0]  ack_vec;
  logic        base_we;
  logic [31:0] base_wdata;
  logic        remap_we;
  logic        remap_sel;
  logic [6:0]  remap_wdata;
  logic        req;
  logic [2:0]  lvl;
  logic [7:0]  vec;
  logic [31:0] vaddr;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    logic        req;
    logic [2:0]  lvl;
    logic [7:0]  vec;
    logic [31:0] addr;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;

  always #10 clk = ~clk;

  prio_intc uut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .mask_i(mask),
    .ack_i(ack), .ack_vec_i(ack_vec),
    .base_we_i(base_we), .base_wdata_i(base_wdata),
    .remap_we_i(remap_we), .remap_sel_i(remap_sel), .remap_wdata_i(remap_wdata),
    .req_o(req), .lvl_o(lvl), .vec_o(vec), .vec_addr_o(vaddr)
  );

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic expect_out(input string tag, input logic r, input logic [2:0] l,
                            input logic [7:0] v, input logic [31:0] a);
    exp_t e;
    e.tag = tag; e.req = r; e.lvl = l; e.vec = v; e.addr = a;
    exp_q.push_back(e);
    -> chk_ev;
    #1;
  endtask

  task automatic write_slot(input logic sel, input logic [6:0] d);
    remap_we = 1'b1; remap_sel = sel; remap_wdata = d;
    step(1);
    remap_we = 1'b0;
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        compared++;
        if (req !== e.req || lvl !== e.lvl || vec !== e.vec || vaddr !== e.addr) begin
          mismatched++;
          $display("FAIL %s: got req=%0b lvl=%0d vec=%0d addr=%h, expected req=%0b lvl=%0d vec=%0d addr=%h",
                   e.tag, req, lvl, vec, vaddr, e.req, e.lvl, e.vec, e.addr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq = '0; mask = 3'd0; ack = 1'b0; ack_vec = '0;
    base_we = 1'b0; base_wdata = '0; remap_we = 1'b0; remap_sel = 1'b0; remap_wdata = '0;
    step(3);
    expect_out("R1 reset state", 1'b0, 3'd0, 8'd0, 32'd0);
    rst_n = 1'b1;
    step(1);
    expect_out("R1 idle after reset", 1'b0, 3'd0, 8'd0, 32'd0);

    // R2 / R4: lowest source, level 1, vector 102
    irq[38] = 1'b1;
    #2;
    expect_out("R11 no change before edge", 1'b0, 3'd0, 8'd0, 32'd0);
    step(1);
    expect_out("R2 src38 level1 vec102", 1'b1, 3'd1, 8'd102, 32'd408);

    // R3: higher level wins
    irq[20] = 1'b1;
    step(1);
    expect_out("R3 src20 beats src38", 1'b1, 3'd4, 8'd84, 32'd336);

    // R3: same level, lower index wins
    irq = '0; irq[12] = 1'b1; irq[9] = 1'b1;
    step(1);
    expect_out("R3 src9 beats src12", 1'b1, 3'd5, 8'd73, 32'd292);

    // R5: masking
    mask = 3'd5;
    step(1);
    expect_out("R5 level5 masked at 5", 1'b0, 3'd5, 8'd73, 32'd292);
    mask = 3'd4;
    step(1);
    expect_out("R5 level5 above mask 4", 1'b1, 3'd5, 8'd73, 32'd292);

    // R6: level-sensitive drops
    irq = '0;
    step(1);
    expect_out("R6 release clears output", 1'b0, 3'd0, 8'd0, 32'd0);

    // R10: base alignment
    mask = 3'd0;
    base_we = 1'b1; base_wdata = 32'h1234_5678;
    step(1);
    base_we = 1'b0;
    irq[3] = 1'b1;
    step(1);
    expect_out("R10 aligned base src3", 1'b1, 3'd6, 8'd67, 32'h1230_010C);
    irq = '0;

    // R7: edge latch on source 0, unmaskable
    mask = 3'd7;
    irq[0] = 1'b1;
    step(1);
    expect_out("R7 edge latched nmi", 1'b1, 3'd7, 8'd64, 32'h1230_0100);
    irq[0] = 1'b0;
    step(1);
    expect_out("R7 held after input falls", 1'b1, 3'd7, 8'd64, 32'h1230_0100);
    ack = 1'b1; ack_vec = 8'd65;
    step(1);
    ack = 1'b0;
    step(1);
    expect_out("R7 wrong vector ack ignored", 1'b1, 3'd7, 8'd64, 32'h1230_0100);
    ack = 1'b1; ack_vec = 8'd64;
    step(1);
    ack = 1'b0;
    step(1);
    expect_out("R7 ack clears latch", 1'b0, 3'd0, 8'd0, 32'd0);
    irq[0] = 1'b1;
    step(1);
    expect_out("R7 new edge latched", 1'b1, 3'd7, 8'd64, 32'h1230_0100);
    ack = 1'b1; ack_vec = 8'd64;
    step(1);
    ack = 1'b0;
    step(1);
    expect_out("R7 held-high no retrigger", 1'b0, 3'd0, 8'd0, 32'd0);
    irq[0] = 1'b0;
    mask = 3'd0;

    // R8: promotion slots
    write_slot(1'b1, {1'b1, 6'd30});
    irq[1] = 1'b1; irq[30] = 1'b1;
    step(1);
    expect_out("R8 slot1 src30 beats src1", 1'b1, 3'd6, 8'd94, 32'h1230_0178);
    write_slot(1'b0, {1'b1, 6'd37});
    irq[37] = 1'b1;
    step(1);
    expect_out("R8 slot0 beats slot1", 1'b1, 3'd6, 8'd101, 32'h1230_0194);

    // R9: invalid slots ignored
    write_slot(1'b0, {1'b1, 6'd45});
    step(1);
    expect_out("R9 out-of-range slot0 ignored", 1'b1, 3'd6, 8'd94, 32'h1230_0178);
    write_slot(1'b0, {1'b0, 6'd37});
    step(1);
    expect_out("R9 invalid-flag slot0 ignored", 1'b1, 3'd6, 8'd94, 32'h1230_0178);

    // R11: slot write takes effect one edge after storing
    remap_we = 1'b1; remap_sel = 1'b0; remap_wdata = {1'b1, 6'd37};
    step(1);
    remap_we = 1'b0;
    expect_out("R11 slot not yet visible", 1'b1, 3'd6, 8'd94, 32'h1230_0178);
    step(1);
    expect_out("R11 slot visible next edge", 1'b1, 3'd6, 8'd101, 32'h1230_0194);

    done = 1;
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule